// File: doc/BRIEF.md
# SMBus Host Controller Register Engine

This block is the software-facing register file and transaction sequencer of an SMBus host. Software fills in a command byte, an address byte (7-bit target address plus a read flag) and up to two data bytes. It then writes the control register with the start bit and a 3-bit protocol code. The block presents one protocol-level transaction on a simple downstream interface and holds it until the downstream side reports completion. Any response data is then written back into the data registers.

A 32-entry byte buffer serves block transfers. Software reaches the buffer through a single data port whose index moves forward after every access and wraps around. The downstream side reads the buffer by index for a block write. For a block read it pushes bytes into the buffer. Bit-level bus signalling, clock stretching and packet error checking belong to the downstream engine and are not part of this block.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0, the status byte reads 0 and txn_req is low.
- R2: Register offsets are: status 0, control 2, command 3, address 4, data0 5, data1 6, block port 7. Offset 1 reads 0. Control stores bits 4:0 of a write, and a read of control returns those bits with bits 7:5 as 0.
- R3: While a transaction is pending, the downstream outputs carry the register values. txn_saddr is address bits 7:1, txn_read is address bit 0, txn_cmd is the command byte (also the payload of a byte send), txn_proto is control bits 4:2, and txn_wdata is {data1, data0}.
- R4: A control write with bit 6 set, made while idle, whose code in bits 4:2 is 0 (quick), 1 (byte), 2 (byte data), 3 (word data) or 5 (block) raises txn_req on the next cycle, sets status bit 0 (busy) and resets the block index to 0.
- R5: A start with any other protocol code sets status bit 2 (failure) and leaves txn_req low.
- R6: txn_done while txn_req is high drops txn_req and busy on the next cycle and sets status bit 1 (done).
- R7: On completion of a read with code 1 or 2, data0 takes txn_rdata[7:0] and data1 is unchanged. A write, or a quick command, changes neither data register.
- R8: On completion of a word-data read, data0 takes txn_rdata[7:0] and data1 takes txn_rdata[15:8].
- R9: During a block read, each cycle with txn_bvalid high stores txn_bdata into the buffer at successive entries, starting at 0. On completion, data0 takes the byte count from txn_rdata[7:0].
- R10: For a block write, txn_count shows data0, and txn_bout shows the buffer entry selected by txn_bsel.
- R11: Every write to or read from the block port accesses the buffer at the current index and then advances the index. After entry 31 the index returns to 0.
- R12: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 leaves it unchanged, and bit 0 cannot be written.
- R13: While busy, writes to offsets 2 to 7 are ignored, including a second start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the block index at offset 7) |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, valid in the same cycle |
| txn_req | output | 1 | Transaction pending |
| txn_proto | output | 3 | Protocol code |
| txn_saddr | output | 7 | Target address |
| txn_read | output | 1 | Read flag |
| txn_cmd | output | 8 | Command byte |
| txn_wdata | output | 16 | Write data {data1, data0} |
| txn_count | output | 8 | Block write byte count (data0) |
| txn_bsel | input | 5 | Buffer entry selected by the downstream side |
| txn_bout | output | 8 | Buffer entry at txn_bsel |
| txn_bvalid | input | 1 | Block read byte strobe |
| txn_bdata | input | 8 | Block read byte |
| txn_done | input | 1 | Transaction complete |
| txn_rdata | input | 16 | Response data (byte, word or block count) |

## Verification
The hardest situation to reach is the wrap of the shared buffer index. A wrap only appears after 32 port accesses with no start request in between, because every start resets the index. The bench writes a full buffer of computed bytes and then reads 33 times, so the last read must return entry 0 again. Writes and ignored requests made during a pending transaction are also hard to reach. The bench holds back txn_done, issues register writes and a second start while busy, and watches the downstream outputs and register readback stay unchanged. A sweep over all eight protocol codes, in both directions, checks acceptance, failure and the capture of results.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
    localparam logic [2:0] OFS_STATUS = 3'd0;
    localparam logic [2:0] OFS_CTRL   = 3'd2;
    localparam logic [2:0] OFS_CMD    = 3'd3;
    localparam logic [2:0] OFS_ADDR   = 3'd4;
    localparam logic [2:0] OFS_DATA0  = 3'd5;
    localparam logic [2:0] OFS_DATA1  = 3'd6;
    localparam logic [2:0] OFS_BLK    = 3'd7;

    localparam logic [2:0] PR_QUICK = 3'd0;
    localparam logic [2:0] PR_BYTE  = 3'd1;
    localparam logic [2:0] PR_BDATA = 3'd2;
    localparam logic [2:0] PR_WDATA = 3'd3;
    localparam logic [2:0] PR_BLOCK = 3'd5;

    localparam int START_BIT = 6;

    function automatic logic proto_ok(input logic [2:0] p);
        return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
               (p == PR_WDATA) || (p == PR_BLOCK);
    endfunction
endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [DW-1:0]          wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem_q[raddr[p]];
    end
endmodule

// File: rtl/smb_rsp_capture.sv
module smb_rsp_capture
    import smb_host_pkg::*;
(
    input  logic [2:0]  proto,
    input  logic        is_read,
    input  logic [15:0] rsp,
    input  logic [7:0]  d0_cur,
    input  logic [7:0]  d1_cur,
    output logic [7:0]  d0_nxt,
    output logic [7:0]  d1_nxt
);
    always_comb begin
        d0_nxt = d0_cur;
        d1_nxt = d1_cur;
        if (is_read) begin
            case (proto)
                PR_BYTE, PR_BDATA, PR_BLOCK: d0_nxt = rsp[7:0];
                PR_WDATA: begin
                    d0_nxt = rsp[7:0];
                    d1_nxt = rsp[15:8];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [2:0]                   reg_addr,
    input  logic [7:0]                   reg_wdata,
    output logic [7:0]                   reg_rdata,
    output logic                         txn_req,
    output logic [2:0]                   txn_proto,
    output logic [6:0]                   txn_saddr,
    output logic                         txn_read,
    output logic [7:0]                   txn_cmd,
    output logic [15:0]                  txn_wdata,
    output logic [7:0]                   txn_count,
    input  logic [$clog2(BUF_DEPTH)-1:0] txn_bsel,
    output logic [7:0]                   txn_bout,
    input  logic                         txn_bvalid,
    input  logic [7:0]                   txn_bdata,
    input  logic                         txn_done,
    input  logic [15:0]                  txn_rdata
);
    localparam int IDXW = $clog2(BUF_DEPTH);

    typedef struct packed {
        logic [4:0]      ctl;
        logic [7:0]      cmd;
        logic [7:0]      saddr;
        logic [7:0]      d0;
        logic [7:0]      d1;
        logic [IDXW-1:0] idx;
        logic [IDXW-1:0] fill;
        logic            busy;
        logic            done;
        logic            fail;
    } regs_t;

    regs_t s_q, s_d;

    logic                   buf_we;
    logic [IDXW-1:0]        buf_waddr;
    logic [7:0]             buf_wdata;
    logic [1:0][IDXW-1:0]   buf_raddr;
    logic [1:0][7:0]        buf_rdata;
    logic [7:0]             cap_d0, cap_d1;
    logic                   host_wr_ok;
    logic                   blk_rd_fill;

    function automatic logic [IDXW-1:0] step_idx(input logic [IDXW-1:0] v);
        return (v == IDXW'(BUF_DEPTH - 1)) ? '0 : v + 1'b1;
    endfunction

    assign buf_raddr[0] = s_q.idx;
    assign buf_raddr[1] = txn_bsel;

    smb_blk_buf #(.DEPTH(BUF_DEPTH), .DW(8), .NRD(2)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    smb_rsp_capture u_cap (
        .proto   (s_q.ctl[4:2]),
        .is_read (s_q.saddr[0]),
        .rsp     (txn_rdata),
        .d0_cur  (s_q.d0),
        .d1_cur  (s_q.d1),
        .d0_nxt  (cap_d0),
        .d1_nxt  (cap_d1)
    );

    assign host_wr_ok  = reg_wr && !s_q.busy;
    assign blk_rd_fill = s_q.busy && s_q.saddr[0] && (s_q.ctl[4:2] == PR_BLOCK) && txn_bvalid;

    always_comb begin
        s_d       = s_q;
        buf_we    = 1'b0;
        buf_waddr = '0;
        buf_wdata = '0;

        if (reg_wr && reg_addr == OFS_STATUS) begin
            if (reg_wdata[1]) s_d.done = 1'b0;
            if (reg_wdata[2]) s_d.fail = 1'b0;
        end

        if (host_wr_ok) begin
            case (reg_addr)
                OFS_CTRL: begin
                    s_d.ctl = reg_wdata[4:0];
                    if (reg_wdata[START_BIT]) begin
                        s_d.idx  = '0;
                        s_d.fill = '0;
                        if (proto_ok(reg_wdata[4:2])) s_d.busy = 1'b1;
                        else                          s_d.fail = 1'b1;
                    end
                end
                OFS_CMD:   s_d.cmd   = reg_wdata;
                OFS_ADDR:  s_d.saddr = reg_wdata;
                OFS_DATA0: s_d.d0    = reg_wdata;
                OFS_DATA1: s_d.d1    = reg_wdata;
                OFS_BLK: begin
                    buf_we    = 1'b1;
                    buf_waddr = s_q.idx;
                    buf_wdata = reg_wdata;
                    s_d.idx   = step_idx(s_q.idx);
                end
                default: ;
            endcase
        end

        if (reg_rd && !reg_wr && reg_addr == OFS_BLK) begin
            s_d.idx = step_idx(s_q.idx);
        end

        if (blk_rd_fill) begin
            buf_we    = 1'b1;
            buf_waddr = s_q.fill;
            buf_wdata = txn_bdata;
            s_d.fill  = step_idx(s_q.fill);
        end

        if (s_q.busy && txn_done) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            s_d.d0   = cap_d0;
            s_d.d1   = cap_d1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_addr)
            OFS_STATUS: reg_rdata = {5'b0, s_q.fail, s_q.done, s_q.busy};
            OFS_CTRL:   reg_rdata = {3'b0, s_q.ctl};
            OFS_CMD:    reg_rdata = s_q.cmd;
            OFS_ADDR:   reg_rdata = s_q.saddr;
            OFS_DATA0:  reg_rdata = s_q.d0;
            OFS_DATA1:  reg_rdata = s_q.d1;
            OFS_BLK:    reg_rdata = buf_rdata[0];
            default:    reg_rdata = 8'h00;
        endcase
    end

    assign txn_req   = s_q.busy;
    assign txn_proto = s_q.ctl[4:2];
    assign txn_saddr = s_q.saddr[7:1];
    assign txn_read  = s_q.saddr[0];
    assign txn_cmd   = s_q.cmd;
    assign txn_wdata = {s_q.d1, s_q.d0};
    assign txn_count = s_q.d0;
    assign txn_bout  = buf_rdata[1];
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk
    import smb_host_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [7:0]  reg_wdata,
    input logic        txn_req,
    input logic [2:0]  txn_proto,
    input logic [6:0]  txn_saddr,
    input logic [7:0]  txn_cmd,
    input logic [15:0] txn_wdata,
    input logic        txn_done
);
    logic start_wr;
    assign start_wr = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[START_BIT];

    // R4: accepted start raises the request
    assert_start_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !txn_req && proto_ok(reg_wdata[4:2])) |=> txn_req);

    // R4: no request appears without a start
    assert_no_spurious_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_req && !start_wr) |=> !txn_req);

    // R5: unknown code never starts
    assert_bad_proto_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !txn_req && !proto_ok(reg_wdata[4:2])) |=> !txn_req);

    // R6: completion drops the request
    assert_done_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && txn_done) |=> !txn_req);

    // R13: pending transaction is frozen until done
    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && !txn_done) |=> (txn_req && $stable(txn_proto) && $stable(txn_saddr)
                                    && $stable(txn_cmd) && $stable(txn_wdata)));
endmodule

bind smb_host_regs smb_host_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .txn_req   (txn_req),
    .txn_proto (txn_proto),
    .txn_saddr (txn_saddr),
    .txn_cmd   (txn_cmd),
    .txn_wdata (txn_wdata),
    .txn_done  (txn_done)
);

// File: tb/smb_host_regs_tb.sv
module smb_host_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        txn_req, txn_read;
    logic [2:0]  txn_proto;
    logic [6:0]  txn_saddr;
    logic [7:0]  txn_cmd, txn_count, txn_bout;
    logic [15:0] txn_wdata;
    logic [4:0]  txn_bsel = '0;
    logic        txn_bvalid = 1'b0;
    logic [7:0]  txn_bdata = '0;
    logic        txn_done = 1'b0;
    logic [15:0] txn_rdata = '0;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    smb_host_regs u_dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic finish_txn(input logic [15:0] r);
        txn_rdata = r; txn_done = 1'b1;
        @(negedge clk);
        txn_done = 1'b0;
    endtask

    function automatic logic [7:0] pat_w(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] pat_r(input int i);
        return 8'((255 - i * 5) & 255);
    endfunction

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(txn_req == 1'b0, "R1 txn_req", txn_req, 0);
        for (int a = 0; a < 8; a++) begin
            if (a == 7) continue;
            rd(3'(a), v);
            chk(v == 8'h00, "R1 register reset", v, 0);
        end

        // Sweep all protocol codes in both directions (R3..R8, R12)
        for (int p = 0; p < 8; p++) begin
            for (int r = 0; r < 2; r++) begin
                logic [6:0]  sa;
                logic [7:0]  cm, d0, d1, e0, e1;
                logic [15:0] rsp;
                bit ok;
                sa  = 7'(7'h20 + p * 3 + r);
                cm  = 8'(8'hA0 ^ (p * 2 + r));
                d0  = 8'(8'h11 * (p + 1));
                d1  = 8'(8'h3C + p);
                rsp = 16'(16'hB100 + p * 16 + r * 3 + 16'h0800);
                ok  = (p <= 3) || (p == 5);
                wr(3'd4, {sa, 1'(r)});
                wr(3'd3, cm);
                wr(3'd5, d0);
                wr(3'd6, d1);
                wr(3'd2, 8'(8'h40 | (p << 2)));
                chk(txn_req == ok, "R4/R5 request on start", txn_req, ok);
                if (ok) begin
                    chk(txn_saddr == sa && txn_read == 1'(r), "R3 address split", {txn_saddr, txn_read}, {sa, 1'(r)});
                    chk(txn_cmd == cm, "R3 command", txn_cmd, cm);
                    chk(txn_proto == 3'(p), "R3 protocol", txn_proto, p);
                    chk(txn_wdata == {d1, d0}, "R3 R8 write data", txn_wdata, {d1, d0});
                    rd(3'd0, v);
                    chk(v == 8'h01, "R4 busy status", v, 1);
                    finish_txn(rsp);
                    chk(txn_req == 1'b0, "R6 request drops", txn_req, 0);
                    rd(3'd0, v);
                    chk(v == 8'h02, "R6 done status", v, 2);
                    e0 = d0; e1 = d1;
                    if (r == 1 && (p == 1 || p == 2 || p == 5)) e0 = rsp[7:0];
                    if (r == 1 && p == 3) begin e0 = rsp[7:0]; e1 = rsp[15:8]; end
                    rd(3'd5, v);
                    chk(v == e0, "R7 R8 R9 data0 result", v, e0);
                    rd(3'd6, v);
                    chk(v == e1, "R7 R8 data1 result", v, e1);
                    wr(3'd0, 8'h04);
                    rd(3'd0, v);
                    chk(v == 8'h02, "R12 write 0 keeps done", v, 2);
                    wr(3'd0, 8'h02);
                end else begin
                    rd(3'd0, v);
                    chk(v == 8'h04, "R5 failure status", v, 4);
                    wr(3'd0, 8'h04);
                end
                rd(3'd0, v);
                chk(v == 8'h00, "R12 status cleared", v, 0);
            end
        end

        // R12 busy bit not writable
        wr(3'd0, 8'h07);
        rd(3'd0, v);
        chk(v == 8'h00, "R12 busy not writable", v, 0);

        // R2 control masking and unmapped offset
        wr(3'd2, 8'hBF);
        rd(3'd2, v);
        chk(v == 8'h1F, "R2 control readback", v, 8'h1F);
        chk(txn_req == 1'b0, "R2 no start without bit 6", txn_req, 0);
        rd(3'd1, v);
        chk(v == 8'h00, "R2 offset 1", v, 0);

        // R11 fill buffer then read 33 times to see wrap (index is 0 after last start)
        for (int i = 0; i < 32; i++) wr(3'd7, pat_w(i));
        for (int i = 0; i < 33; i++) begin
            rd(3'd7, v);
            chk(v == pat_w(i % 32), "R11 block port readback and wrap", v, pat_w(i % 32));
        end

        // R10 block write
        wr(3'd5, 8'd32);
        wr(3'd4, {7'h33, 1'b0});
        wr(3'd2, 8'h54);
        chk(txn_req == 1'b1, "R4 block write start", txn_req, 1);
        chk(txn_count == 8'd32, "R10 byte count", txn_count, 32);
        for (int i = 0; i < 32; i++) begin
            txn_bsel = 5'(i);
            #1;
            chk(txn_bout == pat_w(i), "R10 buffer to downstream", txn_bout, pat_w(i));
        end
        // R13 writes while busy are ignored
        wr(3'd3, 8'hEE);
        wr(3'd7, 8'h99);
        wr(3'd2, 8'h4C);
        txn_bsel = 5'd0;
        #1;
        chk(txn_bout == pat_w(0), "R13 block port write ignored", txn_bout, pat_w(0));
        chk(txn_proto == 3'd5, "R13 control write ignored", txn_proto, 5);
        rd(3'd3, v);
        chk(v == {1'b0, 7'(8'hA0 ^ 15)} || v == 8'(8'hA0 ^ 15), "R13 command write ignored", v, 8'(8'hA0 ^ 15));
        rd(3'd0, v);
        chk(v == 8'h01, "R13 second start ignored", v, 1);
        finish_txn(16'h0000);
        wr(3'd0, 8'h06);

        // R9 block read
        wr(3'd4, {7'h33, 1'b1});
        wr(3'd2, 8'h54);
        for (int i = 0; i < 32; i++) begin
            txn_bvalid = 1'b1; txn_bdata = pat_r(i);
            @(negedge clk);
        end
        txn_bvalid = 1'b0;
        finish_txn(16'h0020);
        rd(3'd5, v);
        chk(v == 8'd32, "R9 block count in data0", v, 32);
        for (int i = 0; i < 32; i++) begin
            rd(3'd7, v);
            chk(v == pat_r(i), "R9 block read bytes", v, pat_r(i));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule